// File: doc/BRIEF.md
# Small-Page NAND Column Pointer Decoder

This block sits on the device side of a byte-wide flash bus. It models how a small-page NAND part turns latched command, address and data bytes into a column position inside a 528-byte page register. Every byte arrives on one write strobe, qualified by a command-latch or address-latch level. Three read commands choose which region of the page a later address offset refers to. These are a lower main half, an upper main half and a 16-byte spare region. The block holds the chosen region between operations, with one exception: the upper-half choice lapses after a single use.

A four-cycle address phase gives an 8-bit offset and a row number. A column counter then steps once for each read or write data strobe. When sequential reads run off the end of a page, the row moves to the next page of a 32-page block. They stop at the final page of the block. A program sequence loads bytes into a local register file that stands in for the page register. A per-region budget limits the partial programs allowed between erases. An identification command returns a fixed four-byte signature.

Top module: `nand_ptr_dec`

## Requirements
- R1: After reset the region is the lower half (area code 0), the column is 0, dout is 00h, and both prog_err and seq_end are low.
- R2: Command 00h selects area code 0 with base column 0. Command 01h selects area code 1 with base column 256. Command 50h selects area code 2 with base column 512. At the end of the address phase the column is the base plus the first address byte; for area code 2 only the low 4 bits of that byte are used.
- R3: Once the address phase of an operation started under area code 1 is complete, the region becomes area code 0, so a following address phase with no command starts in the lower half.
- R4: A read command persists. A new four-byte address phase with no preceding command starts a read in the current region.
- R5: In read mode each read strobe loads dout, one clock later, with the page byte at the current column, and then advances the column by one.
- R6: A read strobe at column 527 on a page that is not the last of its block (row bits 4:0 not all ones) increments the row. It restarts the column at 512 if the region is area code 2, and at 0 otherwise.
- R7: A read strobe at column 527 on the last page of a block raises seq_end. The column then stays at 527, and further read strobes return byte 527 again.
- R8: Address bytes 2, 3 and 4 supply row bits 7:0, 15:8 and 16. Bit 0 of byte 4 is row bit 16.
- R9: Command 90h followed by one address byte makes successive read strobes return ECh, 76h, 5Ah and 3Fh. Any strobe after those four returns 00h.
- R10: After command 80h and a four-byte address, each data byte is written at the current column and the column advances. The column saturates at 527, so later bytes overwrite column 527. Command 10h ends the load.
- R11: A second program load into the main area (area code 0 or 1) without an erase in between sets prog_err when its address phase completes, and none of its data bytes reach the page register.
- R12: The spare area (area code 2) accepts two program loads between erases. A third load sets prog_err and is rejected in the same way.
- R13: Command 60h followed by D0h resets both program budgets. Command 80h clears prog_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cle | input | 1 | Marks the strobed byte as a command |
| ale | input | 1 | Marks the strobed byte as an address byte |
| we_stb | input | 1 | One-cycle write strobe that latches din |
| re_stb | input | 1 | One-cycle read strobe |
| din | input | 8 | Command, address or data byte |
| dout | output | 8 | Byte returned for the most recent read strobe |
| col_ptr | output | 10 | Current column |
| row_addr | output | 17 | Current row (page) address |
| area | output | 2 | Current region code: 0 lower half, 1 upper half, 2 spare |
| prog_err | output | 1 | Current program load was rejected by its budget |
| seq_end | output | 1 | Sequential read reached the end of the block |

## Verification
The bench builds the block with its default parameters: a 16-byte spare region, a 17-bit row, 32 pages per block, and budgets of one main and two spare loads. With these values the spare offset mask, the block-end row value 1Fh and the third spare load that breaks the budget can all be reached in a few thousand cycles. Because the budgets are small, the bench fills the whole main area in one load. It then checks every rejection against bytes it knows are already in place.

// File: rtl/nand_ptr_pkg.sv
package nand_ptr_pkg;

   typedef enum logic [1:0] {
      AREA_A = 2'd0,
      AREA_B = 2'd1,
      AREA_C = 2'd2
   } area_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ID    = 2'd2,
      OP_ERASE = 2'd3
   } op_e;

   localparam logic [7:0] CMD_PTR_A    = 8'h00;
   localparam logic [7:0] CMD_PTR_B    = 8'h01;
   localparam logic [7:0] CMD_PTR_C    = 8'h50;
   localparam logic [7:0] CMD_LOAD     = 8'h80;
   localparam logic [7:0] CMD_COMMIT   = 8'h10;
   localparam logic [7:0] CMD_ERASE    = 8'h60;
   localparam logic [7:0] CMD_ERASE_GO = 8'hD0;
   localparam logic [7:0] CMD_IDENT    = 8'h90;

   function automatic logic [7:0] ident_byte(input logic [2:0] idx);
      case (idx)
         3'd0:    return 8'hEC;
         3'd1:    return 8'h76;
         3'd2:    return 8'h5A;
         3'd3:    return 8'h3F;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/nand_ptr_ctrl.sv
module nand_ptr_ctrl
   import nand_ptr_pkg::*;
#(
   parameter int SPARE_BYTES   = 16,
   parameter int ROW_W         = 17,
   parameter int PAGES_PER_BLK = 32,
   localparam int HALF_BYTES   = 256,
   localparam int MAIN_BYTES   = 2 * HALF_BYTES,
   localparam int LAST_COL     = MAIN_BYTES + SPARE_BYTES - 1,
   localparam int COL_W        = $clog2(LAST_COL + 1),
   localparam int SP_W         = $clog2(SPARE_BYTES),
   localparam int BLK_W        = $clog2(PAGES_PER_BLK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_stb,
   input  logic             addr_stb,
   input  logic             data_stb,
   input  logic             re_stb,
   input  logic [7:0]       din,
   output op_e              op,
   output area_e            area,
   output logic [COL_W-1:0] col,
   output logic [ROW_W-1:0] row,
   output logic             addr_last,
   output logic             load_start,
   output logic             commit,
   output logic             erase_go,
   output logic             rd_fire,
   output logic             id_fire,
   output logic             wr_fire,
   output logic [2:0]       id_idx,
   output logic             seq_end
);

   logic [1:0]       acnt;
   logic [1:0]       idx;
   logic             addr_full;
   logic [7:0]       off_q;
   logic [23:0]      row_raw;
   logic [COL_W-1:0] wrap_col;
   logic [COL_W-1:0] start_col;
   logic             blk_last;

   assign idx        = addr_full ? 2'd0 : acnt;
   assign addr_last  = addr_stb && (op == OP_READ || op == OP_PROG) && idx == 2'd3;
   assign load_start = cmd_stb && din == CMD_LOAD;
   assign commit     = cmd_stb && din == CMD_COMMIT && op == OP_PROG && addr_full;
   assign erase_go   = cmd_stb && din == CMD_ERASE_GO && op == OP_ERASE;
   assign rd_fire    = re_stb && op == OP_READ && addr_full;
   assign id_fire    = re_stb && op == OP_ID && addr_full;
   assign wr_fire    = data_stb && op == OP_PROG && addr_full;
   assign blk_last   = &row_raw[BLK_W-1:0];
   assign row        = row_raw[ROW_W-1:0];

   always_comb begin
      case (area)
         AREA_B:  start_col = COL_W'(HALF_BYTES) + COL_W'(off_q);
         AREA_C:  start_col = COL_W'(MAIN_BYTES) + COL_W'(off_q[SP_W-1:0]);
         default: start_col = COL_W'(off_q);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op        <= OP_READ;
         area      <= AREA_A;
         acnt      <= 2'd0;
         addr_full <= 1'b0;
         off_q     <= 8'h00;
         row_raw   <= 24'h0;
         col       <= '0;
         wrap_col  <= '0;
         seq_end   <= 1'b0;
         id_idx    <= 3'd0;
      end else if (cmd_stb) begin
         case (din)
            CMD_PTR_A, CMD_PTR_B, CMD_PTR_C: begin
               area      <= (din == CMD_PTR_A) ? AREA_A :
                            (din == CMD_PTR_B) ? AREA_B : AREA_C;
               op        <= OP_READ;
               acnt      <= 2'd0;
               addr_full <= 1'b0;
               seq_end   <= 1'b0;
            end
            CMD_LOAD: begin
               op        <= OP_PROG;
               acnt      <= 2'd0;
               addr_full <= 1'b0;
            end
            CMD_COMMIT: begin
               if (op == OP_PROG) begin
                  op        <= OP_READ;
                  acnt      <= 2'd0;
                  addr_full <= 1'b0;
               end
            end
            CMD_ERASE: begin
               op        <= OP_ERASE;
               acnt      <= 2'd0;
               addr_full <= 1'b0;
            end
            CMD_ERASE_GO: begin
               if (op == OP_ERASE) op <= OP_READ;
            end
            CMD_IDENT: begin
               op        <= OP_ID;
               addr_full <= 1'b0;
               id_idx    <= 3'd0;
            end
            default: ;
         endcase
      end else if (addr_stb) begin
         if (op == OP_ID) begin
            addr_full <= 1'b1;
            id_idx    <= 3'd0;
         end else if (op != OP_ERASE) begin
            case (idx)
               2'd0:    off_q          <= din;
               2'd1:    row_raw[7:0]   <= din;
               2'd2:    row_raw[15:8]  <= din;
               default: row_raw[23:16] <= din;
            endcase
            acnt      <= idx + 2'd1;
            addr_full <= (idx == 2'd3);
            if (idx == 2'd3) begin
               col      <= start_col;
               seq_end  <= 1'b0;
               wrap_col <= (area == AREA_C) ? COL_W'(MAIN_BYTES) : '0;
               if (area == AREA_B) area <= AREA_A;
            end
         end
      end else if (rd_fire) begin
         if (!seq_end) begin
            if (col == COL_W'(LAST_COL)) begin
               if (blk_last) begin
                  seq_end <= 1'b1;
               end else begin
                  row_raw <= row_raw + 24'd1;
                  col     <= wrap_col;
               end
            end else begin
               col <= col + 1'b1;
            end
         end
      end else if (id_fire) begin
         if (id_idx != 3'd4) id_idx <= id_idx + 3'd1;
      end else if (wr_fire) begin
         if (col != COL_W'(LAST_COL)) col <= col + 1'b1;
      end
   end

endmodule

// File: rtl/nand_pp_limit.sv
module nand_pp_limit #(
   parameter int MAIN_LIMIT  = 1,
   parameter int SPARE_LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_start,
   input  logic addr_done,
   input  logic spare_sel,
   input  logic commit,
   input  logic clear,
   output logic load_ok,
   output logic prog_err
);

   logic [1:0] below;
   logic       sel_q;

   for (genvar g = 0; g < 2; g++) begin : g_cls
      localparam int LIM = (g == 0) ? MAIN_LIMIT : SPARE_LIMIT;
      localparam int CW  = $clog2(LIM + 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            cnt <= '0;
         end else if (commit && load_ok && int'(sel_q) == g && cnt != CW'(LIM)) begin
            cnt <= cnt + 1'b1;
         end
      end

      assign below[g] = (cnt < CW'(LIM));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         load_ok  <= 1'b0;
         prog_err <= 1'b0;
      end else if (load_start) begin
         load_ok  <= 1'b0;
         prog_err <= 1'b0;
      end else if (addr_done) begin
         sel_q    <= spare_sel;
         load_ok  <= below[spare_sel];
         prog_err <= !below[spare_sel];
      end else if (commit) begin
         load_ok  <= 1'b0;
      end
   end

endmodule

// File: rtl/nand_page_rf.sv
module nand_page_rf #(
   parameter int DEPTH = 528,
   parameter int AW    = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/nand_ptr_dec.sv
module nand_ptr_dec
   import nand_ptr_pkg::*;
#(
   parameter int SPARE_BYTES    = 16,
   parameter int ROW_W          = 17,
   parameter int PAGES_PER_BLK  = 32,
   parameter int MAIN_PP_LIMIT  = 1,
   parameter int SPARE_PP_LIMIT = 2,
   localparam int PAGE_BYTES    = 512 + SPARE_BYTES,
   localparam int LAST_COL      = PAGE_BYTES - 1,
   localparam int COL_W         = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cle,
   input  logic             ale,
   input  logic             we_stb,
   input  logic             re_stb,
   input  logic [7:0]       din,
   output logic [7:0]       dout,
   output logic [COL_W-1:0] col_ptr,
   output logic [ROW_W-1:0] row_addr,
   output logic [1:0]       area,
   output logic             prog_err,
   output logic             seq_end
);

   if (SPARE_BYTES < 2 || SPARE_BYTES > 256 || (SPARE_BYTES & (SPARE_BYTES - 1)) != 0) begin : g_bad_spare
      $error("SPARE_BYTES must be a power of two from 2 to 256");
   end
   if (ROW_W < 9 || ROW_W > 24) begin : g_bad_row
      $error("ROW_W must lie between 9 and 24");
   end
   if (PAGES_PER_BLK < 2 || (PAGES_PER_BLK & (PAGES_PER_BLK - 1)) != 0 || PAGES_PER_BLK > (1 << ROW_W)) begin : g_bad_blk
      $error("PAGES_PER_BLK must be a power of two that fits the row");
   end
   if (MAIN_PP_LIMIT < 1 || SPARE_PP_LIMIT < 1) begin : g_bad_lim
      $error("program budgets must be at least one");
   end

   logic             cmd_stb, addr_stb, data_stb;
   op_e              op;
   area_e            area_q;
   logic [COL_W-1:0] col;
   logic             addr_last, load_start, commit, erase_go;
   logic             rd_fire, id_fire, wr_fire;
   logic [2:0]       id_idx;
   logic             load_ok;
   logic             rf_we;
   logic [7:0]       rf_rdata;

   assign cmd_stb  = we_stb && cle && !ale;
   assign addr_stb = we_stb && ale && !cle;
   assign data_stb = we_stb && !cle && !ale;

   nand_ptr_ctrl #(
      .SPARE_BYTES   (SPARE_BYTES),
      .ROW_W         (ROW_W),
      .PAGES_PER_BLK (PAGES_PER_BLK)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_stb    (cmd_stb),
      .addr_stb   (addr_stb),
      .data_stb   (data_stb),
      .re_stb     (re_stb),
      .din        (din),
      .op         (op),
      .area       (area_q),
      .col        (col),
      .row        (row_addr),
      .addr_last  (addr_last),
      .load_start (load_start),
      .commit     (commit),
      .erase_go   (erase_go),
      .rd_fire    (rd_fire),
      .id_fire    (id_fire),
      .wr_fire    (wr_fire),
      .id_idx     (id_idx),
      .seq_end    (seq_end)
   );

   nand_pp_limit #(
      .MAIN_LIMIT  (MAIN_PP_LIMIT),
      .SPARE_LIMIT (SPARE_PP_LIMIT)
   ) u_limit (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_start (load_start),
      .addr_done  (addr_last && op == OP_PROG),
      .spare_sel  (area_q == AREA_C),
      .commit     (commit),
      .clear      (erase_go),
      .load_ok    (load_ok),
      .prog_err   (prog_err)
   );

   assign rf_we = wr_fire && load_ok;

   nand_page_rf #(
      .DEPTH (PAGE_BYTES),
      .AW    (COL_W)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (col),
      .wdata (din),
      .raddr (col),
      .rdata (rf_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       dout <= 8'h00;
      else if (rd_fire) dout <= rf_rdata;
      else if (id_fire) dout <= ident_byte(id_idx);
   end

   assign col_ptr = col;
   assign area    = area_q;

endmodule

// File: rtl/nand_ptr_dec_chk.sv
module nand_ptr_dec_chk #(
   parameter int COL_W    = 10,
   parameter int LAST_COL = 527
) (
   input logic             clk,
   input logic             rst_n,
   input logic             we_stb,
   input logic             re_stb,
   input logic [COL_W-1:0] col,
   input logic [1:0]       area,
   input logic             addr_last,
   input logic             rd_fire,
   input logic             id_fire,
   input logic [2:0]       id_idx,
   input logic             seq_end,
   input logic             prog_err,
   input logic             rf_we,
   input logic [7:0]       dout
);

   AST_PTR_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_last && area == 2'd1) |=> (area == 2'd0)); // R3

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fire && !seq_end && col != COL_W'(LAST_COL)) |=> (col == COL_W'($past(col) + 1'b1))); // R5

   AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_end && re_stb && !we_stb) |=> $stable(col)); // R7

   AST_ID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (id_fire && id_idx == 3'd0) |=> (dout == 8'hEC)); // R9

   AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_err |-> !rf_we); // R11

endmodule

bind nand_ptr_dec nand_ptr_dec_chk #(
   .COL_W    (COL_W),
   .LAST_COL (LAST_COL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .we_stb    (we_stb),
   .re_stb    (re_stb),
   .col       (col),
   .area      (area),
   .addr_last (addr_last),
   .rd_fire   (rd_fire),
   .id_fire   (id_fire),
   .id_idx    (id_idx),
   .seq_end   (seq_end),
   .prog_err  (prog_err),
   .rf_we     (rf_we),
   .dout      (dout)
);

// File: tb/nand_ptr_dec_tb.sv
module nand_ptr_dec_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cle = 1'b0, ale = 1'b0, we_stb = 1'b0, re_stb = 1'b0;
   logic [7:0]  din = 8'h00;
   logic [7:0]  dout;
   logic [9:0]  col_ptr;
   logic [16:0] row_addr;
   logic [1:0]  area;
   logic        prog_err, seq_end;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   nand_ptr_dec u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cle      (cle),
      .ale      (ale),
      .we_stb   (we_stb),
      .re_stb   (re_stb),
      .din      (din),
      .dout     (dout),
      .col_ptr  (col_ptr),
      .row_addr (row_addr),
      .area     (area),
      .prog_err (prog_err),
      .seq_end  (seq_end)
   );

   function automatic logic [7:0] pat(input int c);
      logic [7:0] v;
      v = 8'(c * 3);
      if (c >= 256) v = v ^ 8'hC3;
      return v;
   endfunction

   task automatic check(input string what, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic strobe(input logic c, input logic a, input logic [7:0] b);
      @(negedge clk);
      cle = c; ale = a; din = b; we_stb = 1'b1;
      @(negedge clk);
      cle = 1'b0; ale = 1'b0; we_stb = 1'b0;
   endtask

   task automatic do_cmd(input logic [7:0] b);  strobe(1'b1, 1'b0, b); endtask
   task automatic do_addr(input logic [7:0] b); strobe(1'b0, 1'b1, b); endtask
   task automatic do_data(input logic [7:0] b); strobe(1'b0, 1'b0, b); endtask

   task automatic addr4(input logic [7:0] off, input logic [23:0] r);
      do_addr(off);
      do_addr(r[7:0]);
      do_addr(r[15:8]);
      do_addr(r[23:16]);
   endtask

   task automatic do_re(output logic [7:0] b);
      @(negedge clk);
      re_stb = 1'b1;
      @(negedge clk);
      re_stb = 1'b0;
      b = dout;
   endtask

   task automatic t_reset();
      check("R1 dout", dout, 8'h00);
      check("R1 area", area, 0);
      check("R1 col", col_ptr, 0);
      check("R1 prog_err", prog_err, 0);
      check("R1 seq_end", seq_end, 0);
   endtask

   task automatic t_load_base();
      do_cmd(8'h00);
      do_cmd(8'h80);
      addr4(8'h00, 24'h0);
      check("R10 no error on first main load", prog_err, 0);
      for (int c = 0; c < 512; c++) do_data(pat(c));
      check("R10 column after 512 bytes", col_ptr, 512);
      do_cmd(8'h10);
      do_cmd(8'h50);
      do_cmd(8'h80);
      addr4(8'h00, 24'h0);
      for (int i = 0; i < 16; i++) do_data(8'hA0 + 8'(i));
      check("R10 column saturates at 527", col_ptr, 527);
      do_cmd(8'h10);
   endtask

   task automatic t_area_reads();
      logic [7:0] b;
      do_cmd(8'h00);
      addr4(8'h05, 24'h0);
      check("R2 area A start", col_ptr, 5);
      for (int i = 0; i < 3; i++) begin
         do_re(b);
         check("R5 sequential byte", b, pat(5 + i));
      end
      check("R5 column advanced", col_ptr, 8);
      do_cmd(8'h01);
      check("R2 area B code", area, 1);
      addr4(8'h10, 24'h0);
      check("R2 area B start", col_ptr, 272);
      check("R3 pointer back to A", area, 0);
      do_re(b);
      check("R2 area B byte", b, pat(272));
      addr4(8'h03, 24'h0);
      check("R3 R4 address without command in A", col_ptr, 3);
      do_re(b);
      check("R4 persisted read byte", b, pat(3));
      do_cmd(8'h50);
      addr4(8'h02, 24'h0);
      check("R2 area C start", col_ptr, 514);
      check("R2 area C code", area, 2);
      do_re(b);
      check("R2 spare byte", b, 8'hA2);
      addr4(8'hF4, 24'h0);
      check("R2 spare offset masked", col_ptr, 516);
   endtask

   task automatic t_row_assembly();
      do_cmd(8'h00);
      addr4(8'h00, 24'h01_12_34);
      check("R8 row from bytes 2 to 4", row_addr, 17'h11234);
   endtask

   task automatic t_row_wrap();
      logic [7:0] b;
      do_cmd(8'h50);
      addr4(8'h1E, 24'h5);
      check("R6 start col", col_ptr, 526);
      do_re(b);
      check("R6 byte 526", b, 8'hAE);
      do_re(b);
      check("R6 byte 527", b, 8'hAF);
      check("R6 next row", row_addr, 6);
      check("R6 restart in spare", col_ptr, 512);
      do_re(b);
      check("R6 first spare byte of next page", b, 8'hA0);
   endtask

   task automatic t_block_end();
      logic [7:0] b;
      do_cmd(8'h50);
      addr4(8'h0F, 24'h3F);
      check("R7 at last column", col_ptr, 527);
      check("R7 seq_end clear before end", seq_end, 0);
      do_re(b);
      check("R7 last byte", b, 8'hAF);
      check("R7 seq_end raised", seq_end, 1);
      check("R7 column held", col_ptr, 527);
      do_re(b);
      check("R7 repeat last byte", b, 8'hAF);
      check("R7 row unchanged", row_addr, 17'h3F);
   endtask

   task automatic t_ident();
      logic [7:0] b;
      logic [7:0] exp [5] = '{8'hEC, 8'h76, 8'h5A, 8'h3F, 8'h00};
      do_cmd(8'h90);
      do_addr(8'h00);
      for (int i = 0; i < 5; i++) begin
         do_re(b);
         check($sformatf("R9 ident byte %0d", i), b, exp[i]);
      end
   endtask

   task automatic t_main_limit();
      logic [7:0] b;
      do_cmd(8'h00);
      do_cmd(8'h80);
      addr4(8'h00, 24'h0);
      check("R11 second main load rejected", prog_err, 1);
      do_data(8'h00);
      do_cmd(8'h10);
      do_cmd(8'h00);
      addr4(8'h00, 24'h0);
      do_re(b);
      check("R11 page byte unchanged", b, pat(0));
   endtask

   task automatic t_spare_limit();
      logic [7:0] b;
      do_cmd(8'h50);
      do_cmd(8'h80);
      addr4(8'h03, 24'h0);
      check("R12 second spare load allowed", prog_err, 0);
      do_data(8'h77);
      do_cmd(8'h10);
      do_cmd(8'h80);
      addr4(8'h03, 24'h0);
      check("R12 third spare load rejected", prog_err, 1);
      do_data(8'h99);
      do_cmd(8'h10);
      do_cmd(8'h50);
      addr4(8'h03, 24'h0);
      do_re(b);
      check("R12 spare byte keeps accepted value", b, 8'h77);
   endtask

   task automatic t_erase_sat();
      logic [7:0] b;
      do_cmd(8'h60);
      do_addr(8'h00);
      do_addr(8'h00);
      do_addr(8'h00);
      do_cmd(8'hD0);
      do_cmd(8'h80);
      check("R13 load command clears error", prog_err, 0);
      addr4(8'h0E, 24'h0);
      check("R13 spare budget restored", prog_err, 0);
      do_data(8'h11);
      do_data(8'h22);
      do_data(8'h33);
      check("R10 column held at end", col_ptr, 527);
      do_cmd(8'h10);
      do_cmd(8'h50);
      addr4(8'h0E, 24'h0);
      do_re(b);
      check("R10 byte 526", b, 8'h11);
      do_re(b);
      check("R10 byte 527 overwritten", b, 8'h33);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_base();
      t_area_reads();
      t_row_assembly();
      t_row_wrap();
      t_block_end();
      t_ident();
      t_main_limit();
      t_spare_limit();
      t_erase_sat();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule